// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 40-bit physical address by walking a two-level page table in memory. The walk starts from a root register that holds the directory base. It accepts one translation request at a time. It reads the directory entry and, for small pages, the table entry below it, and it finishes with one response that carries the physical address, the granted permissions and the fault status. The page size is either 4 KB or 4 MB. A 4 MB page is allowed only when large pages are enabled, and its entry supplies eight extra physical address bits.

While it walks, the block keeps the accessed and dirty flags of the entries up to date through single-word writes on the same memory port. When translation is switched off, the address passes straight through. When a walk fails, the block reports an error code that gives the fault kind and the access attributes, and it latches the failing linear address.

Memory traffic uses a request/acknowledge handshake with one access outstanding and any latency. Access type encoding: 0 = read, 1 = write, 2 = instruction fetch. Permission bits: bit 0 = read, bit 1 = write, bit 2 = execute.

Top module: `ptw_walker`

## Requirements
- R1: With pg_en low, an accepted request completes with done in the next cycle. It returns pa = {8'h00, linear address} and prot = 3'b111, and it makes no memory access.
- R2: The directory entry is read at {cr3[31:12], la[31:22], 2'b00}. The table entry is read at {pde[31:12], la[21:12], 2'b00}.
- R3: An entry with bit 0 clear ends the walk with a fault. Error code bit 0 is then clear, and no later read or write takes place.
- R4: When pse_en is high and directory bit 7 is set, the walk ends at the directory with a 4 MB page, pa = {pde[20:13], pde[31:22], la[21:0]}. In that case a set bit 21 gives a reserved fault with error bits 0 and 3 set. When pse_en is low, bit 7 is ignored and a table entry is read.
- R5: On a 4 KB walk whose directory entry has bit 5 clear, the entry with bit 5 set is written back to the directory address before the table entry is read. If bit 5 is already set, no such write occurs.
- R6: The user flag (bit 2) and the writable flag (bit 1) of the two levels are ANDed. The access faults with error bit 0 set in three cases: a user access to a page without the user flag, a user write to a non-writable page, or a supervisor write to a non-writable page while wp_en is high.
- R7: With smep_en high, a supervisor fetch from a page that has the user flag faults with error bits 0 and 4 set. User fetches and fetches with smep_en low are allowed.
- R8: On success the final entry gets bit 5 set, and also bit 6 on a write. The entry is written back exactly once if that changed it, and not at all otherwise.
- R9: The returned write permission is cleared when the final entry, after its update, has bit 6 clear.
- R10: Error code: bit 0 = protection or reserved fault, bit 1 = write access, bit 2 = user access, bit 3 = reserved fault, bit 4 = fetch while smep_en is high.
- R11: cr2 is zero after reset. It takes the linear address of every faulting request and holds its value across successful ones.
- R12: A successful 4 KB walk returns pa = {8'h00, pte[31:12], la[11:0]}. A faulting walk returns pa = 0 and prot = 0.
- R13: Each accepted request gives exactly one single-cycle done. A pending memory access keeps mem_req, mem_we and mem_addr steady until mem_ack, and req_ready is low while a walk runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_addr | input | 32 | Linear address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | Access made at user privilege |
| cr3 | input | 32 | Directory base register |
| pg_en | input | 1 | Translation enable |
| pse_en | input | 1 | Large page enable |
| wp_en | input | 1 | Supervisor write protection enable |
| smep_en | input | 1 | Supervisor fetch protection enable |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Pending access is a write |
| mem_addr | output | 32 | Memory word address (byte address) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| done | output | 1 | Result valid for one cycle |
| fault | output | 1 | Result is a page fault (with done) |
| pa | output | 40 | Physical address |
| prot | output | 3 | Granted permissions: read, write, execute |
| err_code | output | 5 | Fault error code |
| cr2 | output | 32 | Last faulting linear address |

## Verification
The assertions assume a memory that raises mem_ack only while mem_req is high. They also assume that cr3 and the control inputs stay fixed while a walk runs, and that req_acc never takes the value 3. The bench responder acknowledges only pending accesses, after a latency that cycles from zero to three wait cycles. The bench changes cr3 and the control bits only between requests, while the block is idle, and it issues only the three defined access types.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int LA_W   = 32;
  localparam int ENT_W  = 32;
  localparam int HI_W   = 8;
  localparam int PA_W   = LA_W + HI_W;
  localparam int ERR_W  = 5;
  localparam int PROT_W = 3;

  localparam int BIT_P       = 0;
  localparam int BIT_RW      = 1;
  localparam int BIT_US      = 2;
  localparam int BIT_ACC     = 5;
  localparam int BIT_DRT     = 6;
  localparam int BIT_BIG     = 7;
  localparam int BIT_BIG_RSV = 21;

  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_EX = 2'd2;

  typedef enum logic [1:0] {FK_NONE, FK_ABSENT, FK_PROT, FK_RSVD} fkind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_DIR, S_SET_DIR_A, S_RD_TBL, S_WB_FINAL, S_RESP
  } walk_st_e;

  function automatic logic [LA_W-1:0] dir_slot(logic [LA_W-1:0] root, logic [LA_W-1:0] la);
    return {root[31:12], la[31:22], 2'b00};
  endfunction

  function automatic logic [LA_W-1:0] tbl_slot(logic [ENT_W-1:0] pde, logic [LA_W-1:0] la);
    return {pde[31:12], la[21:12], 2'b00};
  endfunction

  function automatic logic [PA_W-1:0] pa_small(logic [ENT_W-1:0] pte, logic [LA_W-1:0] la);
    return {{HI_W{1'b0}}, pte[31:12], la[11:0]};
  endfunction

  function automatic logic [PA_W-1:0] pa_big(logic [ENT_W-1:0] pde, logic [LA_W-1:0] la);
    return {pde[20:13], pde[31:22], la[21:0]};
  endfunction
endpackage

// File: rtl/ptw_perm.sv
module ptw_perm
  import ptw_pkg::*;
(
  input  logic              ent_user,
  input  logic              ent_rw,
  input  logic [1:0]        acc,
  input  logic              usr,
  input  logic              wp,
  input  logic              smep,
  output logic [PROT_W-1:0] grant,
  output logic              deny
);
  logic wr_ok;
  logic ex_ok;

  always_comb begin
    wr_ok = ent_rw | (~usr & ~wp);
    ex_ok = ~(smep & ent_user & ~usr);
    grant = {ex_ok, wr_ok, 1'b1};
    deny  = (usr & ~ent_user)
          | ((acc == ACC_WR) & ~wr_ok)
          | ((acc == ACC_EX) & ~ex_ok);
  end
endmodule

// File: rtl/ptw_errgen.sv
module ptw_errgen
  import ptw_pkg::*;
(
  input  fkind_e           kind,
  input  logic [1:0]       acc,
  input  logic             usr,
  input  logic             smep,
  output logic [ERR_W-1:0] err
);
  always_comb begin
    err[0] = (kind == FK_PROT) || (kind == FK_RSVD);
    err[1] = (acc == ACC_WR);
    err[2] = usr;
    err[3] = (kind == FK_RSVD);
    err[4] = (acc == ACC_EX) && smep;
  end
endmodule

// File: rtl/ptw_update.sv
module ptw_update
  import ptw_pkg::*;
(
  input  logic [ENT_W-1:0] ent,
  input  logic             is_wr,
  output logic [ENT_W-1:0] ent_new,
  output logic             changed
);
  always_comb begin
    ent_new          = ent;
    ent_new[BIT_ACC] = 1'b1;
    if (is_wr) ent_new[BIT_DRT] = 1'b1;
    changed = (ent_new != ent);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LA_W-1:0]   req_addr,
  input  logic [1:0]        req_acc,
  input  logic              req_user,
  input  logic [LA_W-1:0]   cr3,
  input  logic              pg_en,
  input  logic              pse_en,
  input  logic              wp_en,
  input  logic              smep_en,
  output logic              mem_req,
  output logic              mem_we,
  output logic [LA_W-1:0]   mem_addr,
  output logic [ENT_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  input  logic [ENT_W-1:0]  mem_rdata,
  output logic              done,
  output logic              fault,
  output logic [PA_W-1:0]   pa,
  output logic [PROT_W-1:0] prot,
  output logic [ERR_W-1:0]  err_code,
  output logic [LA_W-1:0]   cr2
);
  walk_st_e          st;
  logic [LA_W-1:0]   la_q;
  logic [1:0]        acc_q;
  logic              usr_q;
  logic [LA_W-1:0]   root_q;
  logic              pse_q;
  logic              wp_q;
  logic              smep_q;
  logic [ENT_W-1:0]  dir_q;
  logic [LA_W-1:0]   fin_addr_q;
  logic [ENT_W-1:0]  fin_new_q;
  logic [PA_W-1:0]   pa_q;
  logic [PROT_W-1:0] prot_q;
  logic              fault_q;
  logic [ERR_W-1:0]  err_q;
  logic [LA_W-1:0]   cr2_q;

  // named internal events
  logic              in_read;
  logic              walk_big;
  logic              last_step;
  logic              cand_user;
  logic              cand_rw;
  logic [PROT_W-1:0] grant;
  logic              deny;
  logic [ENT_W-1:0]  upd_val;
  logic              upd_chg;
  fkind_e            step_kind;
  logic [ERR_W-1:0]  step_err;
  logic [ENT_W-1:0]  dir_with_a;
  logic [LA_W-1:0]   unused_root_lo;

  assign unused_root_lo = root_q;

  assign in_read   = (st == S_RD_DIR) || (st == S_RD_TBL);
  assign walk_big  = (st == S_RD_DIR) && mem_rdata[BIT_BIG] && pse_q;
  assign last_step = walk_big || (st == S_RD_TBL);
  assign cand_user = (st == S_RD_TBL) ? (dir_q[BIT_US] & mem_rdata[BIT_US]) : mem_rdata[BIT_US];
  assign cand_rw   = (st == S_RD_TBL) ? (dir_q[BIT_RW] & mem_rdata[BIT_RW]) : mem_rdata[BIT_RW];

  always_comb begin
    dir_with_a          = dir_q;
    dir_with_a[BIT_ACC] = 1'b1;
  end

  ptw_perm u_perm (
    .ent_user (cand_user),
    .ent_rw   (cand_rw),
    .acc      (acc_q),
    .usr      (usr_q),
    .wp       (wp_q),
    .smep     (smep_q),
    .grant    (grant),
    .deny     (deny)
  );

  ptw_update u_upd (
    .ent     (mem_rdata),
    .is_wr   (acc_q == ACC_WR),
    .ent_new (upd_val),
    .changed (upd_chg)
  );

  always_comb begin
    step_kind = FK_NONE;
    if (!mem_rdata[BIT_P])                      step_kind = FK_ABSENT;
    else if (walk_big && mem_rdata[BIT_BIG_RSV]) step_kind = FK_RSVD;
    else if (last_step && deny)                  step_kind = FK_PROT;
  end

  ptw_errgen u_err (
    .kind (step_kind),
    .acc  (acc_q),
    .usr  (usr_q),
    .smep (smep_q),
    .err  (step_err)
  );

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_RD_DIR:    mem_addr = dir_slot(root_q, la_q);
      S_SET_DIR_A: begin
        mem_addr  = dir_slot(root_q, la_q);
        mem_wdata = dir_with_a;
      end
      S_RD_TBL:    mem_addr = tbl_slot(dir_q, la_q);
      S_WB_FINAL:  begin
        mem_addr  = fin_addr_q;
        mem_wdata = fin_new_q;
      end
      default: ;
    endcase
  end

  assign mem_req   = in_read || (st == S_SET_DIR_A) || (st == S_WB_FINAL);
  assign mem_we    = (st == S_SET_DIR_A) || (st == S_WB_FINAL);
  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_RESP);
  assign fault     = done && fault_q;
  assign pa        = pa_q;
  assign prot      = prot_q;
  assign err_code  = err_q;
  assign cr2       = cr2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      la_q       <= '0;
      acc_q      <= ACC_RD;
      usr_q      <= 1'b0;
      root_q     <= '0;
      pse_q      <= 1'b0;
      wp_q       <= 1'b0;
      smep_q     <= 1'b0;
      dir_q      <= '0;
      fin_addr_q <= '0;
      fin_new_q  <= '0;
      pa_q       <= '0;
      prot_q     <= '0;
      fault_q    <= 1'b0;
      err_q      <= '0;
      cr2_q      <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            la_q   <= req_addr;
            acc_q  <= req_acc;
            usr_q  <= req_user;
            root_q <= cr3;
            pse_q  <= pse_en;
            wp_q   <= wp_en;
            smep_q <= smep_en;
            if (!pg_en) begin
              pa_q    <= {{HI_W{1'b0}}, req_addr};
              prot_q  <= '1;
              fault_q <= 1'b0;
              st      <= S_RESP;
            end else begin
              st <= S_RD_DIR;
            end
          end
        end
        S_RD_DIR, S_RD_TBL: begin
          if (mem_ack) begin
            if (step_kind != FK_NONE) begin
              fault_q <= 1'b1;
              err_q   <= step_err;
              pa_q    <= '0;
              prot_q  <= '0;
              cr2_q   <= la_q;
              st      <= S_RESP;
            end else if (!last_step) begin
              dir_q <= mem_rdata;
              st    <= mem_rdata[BIT_ACC] ? S_RD_TBL : S_SET_DIR_A;
            end else begin
              fault_q    <= 1'b0;
              pa_q       <= walk_big ? pa_big(mem_rdata, la_q) : pa_small(mem_rdata, la_q);
              prot_q     <= {grant[2], grant[1] & upd_val[BIT_DRT], grant[0]};
              fin_addr_q <= mem_addr;
              fin_new_q  <= upd_val;
              st         <= upd_chg ? S_WB_FINAL : S_RESP;
            end
          end
        end
        S_SET_DIR_A: if (mem_ack) st <= S_RD_TBL;
        S_WB_FINAL:  if (mem_ack) st <= S_RESP;
        S_RESP:      st <= S_IDLE;
        default:     st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
  import ptw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LA_W-1:0]   req_addr,
  input logic              pg_en,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [LA_W-1:0]   mem_addr,
  input logic [ENT_W-1:0]  mem_wdata,
  input logic              done,
  input logic              fault,
  input logic [PA_W-1:0]   pa,
  input logic [PROT_W-1:0] prot,
  input logic [ERR_W-1:0]  err_code,
  input logic [LA_W-1:0]   cr2,
  input logic [1:0]        acc_q,
  input logic              usr_q,
  input logic [LA_W-1:0]   la_q
);
  AST_IDENT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !pg_en) |=> (done && !fault && prot == 3'b111 && pa == {8'h00, $past(req_addr)})); // R1

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R13

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready); // R13

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R13

  AST_WB_SETS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[BIT_ACC]); // R8

  AST_ERR_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (err_code[1] == (acc_q == ACC_WR) && err_code[2] == usr_q)); // R10

  AST_RSVD_IS_P: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && err_code[3]) |-> err_code[0]); // R10

  AST_CR2_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (cr2 == la_q)); // R11

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (pa == '0 && prot == '0)); // R12

  AST_WRITE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && acc_q == ACC_WR) |-> (prot[1] && prot[0])); // R9
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .pg_en     (pg_en),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .done      (done),
  .fault     (fault),
  .pa        (pa),
  .prot      (prot),
  .err_code  (err_code),
  .cr2       (cr2),
  .acc_q     (acc_q),
  .usr_q     (usr_q),
  .la_q      (la_q)
);

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic [31:0] cr3 = 32'h0000_5ABC;
  logic        pg_en = 1'b0, pse_en = 1'b0, wp_en = 1'b0, smep_en = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, fault;
  logic [39:0] pa;
  logic [2:0]  prot;
  logic [4:0]  err_code;
  logic [31:0] cr2;

  always #4 clk = ~clk; // 125 MHz

  ptw_walker u_ptw_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_acc(req_acc), .req_user(req_user), .cr3(cr3),
    .pg_en(pg_en), .pse_en(pse_en), .wp_en(wp_en), .smep_en(smep_en),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .fault(fault),
    .pa(pa), .prot(prot), .err_code(err_code), .cr2(cr2)
  );

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, xfer_cnt = 0, addr_moves = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_cr2 = '0;

  typedef struct {
    logic [39:0] pa; logic [2:0] prot; logic flt; logic [4:0] err; logic [31:0] la;
    logic [31:0] da, dv, ta, tv; bit has_d, has_t; int nwr, nxf, wr_base, xf_base;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  // reference walk computed from the requirements
  function automatic exp_t ref_walk(input logic [31:0] la, input logic [1:0] acc, input logic usr);
    exp_t e;
    logic [31:0] d, t, fin, nf;
    bit wr, fe, big, u, rw, pw, px;
    int kind; // 0 ok, 1 absent, 2 protection, 3 reserved
    e = '{default: 0};
    e.la = la; wr = (acc == 2'd1); fe = (acc == 2'd2);
    big = 0; u = 0; rw = 0; t = 0; fin = 0; kind = 0;
    if (!pg_en) begin
      e.pa = {8'h00, la}; e.prot = 3'b111; return e;
    end
    e.da = {cr3[31:12], la[31:22], 2'b00}; d = rd(e.da);
    e.dv = d; e.has_d = 1; e.nxf = 1;
    if (!d[0]) kind = 1;
    else if (d[7] && pse_en) begin
      big = 1;
      if (d[21]) kind = 3; else begin u = d[2]; rw = d[1]; fin = d; end
    end else begin
      if (!d[5]) begin e.dv = d | 32'h20; e.nwr++; end
      e.ta = {d[31:12], la[21:12], 2'b00}; t = rd(e.ta);
      e.tv = t; e.has_t = 1; e.nxf++;
      if (!t[0]) kind = 1; else begin u = d[2] & t[2]; rw = d[1] & t[1]; fin = t; end
    end
    if (kind == 0) begin
      pw = rw || (!usr && !wp_en);
      px = !(smep_en && u && !usr);
      if ((usr && !u) || (wr && !pw) || (fe && !px)) kind = 2;
      else begin
        nf = fin | 32'h20 | (wr ? 32'h40 : 32'h0);
        if (nf != fin) begin
          e.nwr++;
          if (big) e.dv = nf; else e.tv = nf;
        end
        e.prot = {px, pw && nf[6], 1'b1};
        e.pa = big ? {d[20:13], d[31:22], la[21:0]} : {8'h00, t[31:12], la[11:0]};
      end
    end
    if (kind != 0) begin
      e.flt = 1; e.pa = 0; e.prot = 0;
      e.err = {fe && smep_en, kind == 3, usr, wr, kind >= 2};
    end
    e.nxf += e.nwr;
    return e;
  endfunction

  // memory responder, latency cycles 0..3
  int wait_left = 0, lat_ctr = 0;
  bit busy = 0;
  logic [31:0] hold_addr = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; busy = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (!busy) begin
        busy = 1; wait_left = lat_ctr; lat_ctr = (lat_ctr + 1) % 4; hold_addr = mem_addr;
      end
      if (hold_addr != mem_addr) addr_moves++;
      if (wait_left == 0) begin
        mem_ack = 1'b1; busy = 0; xfer_cnt++;
        if (mem_we) begin mem[mem_addr] = mem_wdata; wr_cnt++; end
        else mem_rdata = rd(mem_addr);
      end else wait_left--;
    end
  end

  // monitor / scoreboard
  exp_t  m_e;
  string m_t;
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk(0, "R13", "unexpected done", 64'd1, 64'd0);
      else begin
        m_e = exp_q.pop_front(); m_t = tag_q.pop_front();
        chk(pa == m_e.pa && prot == m_e.prot && fault == m_e.flt && (!m_e.flt || err_code == m_e.err),
            m_t, "fault/err/prot/pa", {15'd0, fault, err_code, prot, pa},
            {15'd0, m_e.flt, m_e.err, m_e.prot, m_e.pa});
        if (m_e.flt) exp_cr2 = m_e.la;
        chk(cr2 == exp_cr2, "R11", "cr2", {32'd0, cr2}, {32'd0, exp_cr2});
        chk((wr_cnt - m_e.wr_base) == m_e.nwr && (xfer_cnt - m_e.xf_base) == m_e.nxf,
            m_t, "writes/transfers", {32'(wr_cnt - m_e.wr_base), 32'(xfer_cnt - m_e.xf_base)},
            {32'(m_e.nwr), 32'(m_e.nxf)});
        if (m_e.has_d) chk(rd(m_e.da) == m_e.dv, m_t, "directory entry", {32'd0, rd(m_e.da)}, {32'd0, m_e.dv});
        if (m_e.has_t) chk(rd(m_e.ta) == m_e.tv, m_t, "table entry", {32'd0, rd(m_e.ta)}, {32'd0, m_e.tv});
      end
    end
  end

  task automatic walk(input logic [31:0] la, input logic [1:0] acc, input logic usr, input string tag);
    exp_t e;
    e = ref_walk(la, acc, usr);
    e.wr_base = wr_cnt; e.xf_base = xfer_cnt;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = la; req_acc = acc; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  function automatic logic [31:0] mk_la(input int dir, input int tbl, input int off);
    return {dir[9:0], tbl[9:0], off[11:0]};
  endfunction

  bit finished = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R13 watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    mem[32'h0000_5004] = 32'h0000_7007;
    mem[32'h0000_7008] = 32'h0012_3007;
    mem[32'h0000_5010] = 32'h0000_8023;
    mem[32'h0000_8000] = 32'h0040_0067;
    mem[32'h0000_5014] = 32'h0000_9027;
    mem[32'h0000_9000] = 32'h0050_0025;
    mem[32'h0000_5020] = 32'hC00B_4087;
    mem[32'h0000_5024] = 32'h0020_0087;
    mem[32'h0000_5028] = 32'h0000_A0A7;
    mem[32'h0000_A000] = 32'h0060_0067;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !fault && !mem_req, "R13", "reset idle",
        {60'd0, req_ready, done, fault, mem_req}, 64'h8);
    chk(cr2 == 32'h0, "R11", "cr2 after reset", {32'd0, cr2}, 64'd0);

    pg_en = 0;
    walk(32'hDEAD_BEEF, 2'd1, 1'b1, "R1 identity map");
    pg_en = 1; pse_en = 1; wp_en = 0; smep_en = 0;
    walk(mk_la(1, 2, 12'hABC), 2'd0, 1'b0, "R2 R5 R8 R9 R12 first read");
    walk(mk_la(1, 2, 12'h123), 2'd1, 1'b1, "R5 R8 R9 user write sets dirty");
    walk(mk_la(1, 2, 12'h004), 2'd0, 1'b1, "R8 no write when unchanged");
    walk(mk_la(3, 0, 12'h010), 2'd1, 1'b1, "R3 R10 R11 absent directory");
    smep_en = 1;
    walk(mk_la(1, 5, 12'h020), 2'd2, 1'b0, "R3 R10 absent table fetch");
    smep_en = 0;
    walk(mk_la(4, 0, 12'h030), 2'd0, 1'b1, "R6 user to supervisor page");
    walk(mk_la(5, 0, 12'h040), 2'd1, 1'b1, "R6 user write read-only");
    walk(mk_la(5, 0, 12'h044), 2'd1, 1'b0, "R6 R9 supervisor write wp off");
    wp_en = 1;
    walk(mk_la(5, 0, 12'h048), 2'd1, 1'b0, "R6 R10 supervisor write wp on");
    wp_en = 0;
    walk(mk_la(8, 10'h345, 12'h678), 2'd0, 1'b1, "R4 R8 R9 large page read");
    walk(mk_la(8, 10'h001, 12'h002), 2'd1, 1'b1, "R4 R8 large page write");
    walk(mk_la(9, 0, 12'h050), 2'd0, 1'b0, "R4 R10 large reserved bit");
    pse_en = 0;
    walk(mk_la(10, 0, 12'h060), 2'd0, 1'b0, "R4 R12 large flag ignored");
    pse_en = 1; smep_en = 1;
    walk(mk_la(1, 2, 12'h070), 2'd2, 1'b0, "R7 R10 supervisor fetch user page");
    walk(mk_la(1, 2, 12'h074), 2'd2, 1'b1, "R7 user fetch allowed");
    smep_en = 0;
    walk(mk_la(1, 2, 12'h078), 2'd2, 1'b0, "R7 fetch smep off");
    pg_en = 0;
    walk(32'h0000_1234, 2'd2, 1'b0, "R1 R11 identity keeps cr2");

    chk(addr_moves == 0, "R13", "address stable while pending", 64'(addr_moves), 64'd0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule